// File: doc/BRIEF.md
# MAC Address Table with Aging

This block holds a small, fully associative set of MAC address entries for a switch datapath. Three independent paths act on it every cycle. A source-address path learns the address of each received frame: a new address is given a free slot as a dynamic entry, and a known dynamic address has its port refreshed. A destination-address path searches the table without a clock and reports whether the address is known, the egress port, a drop indication, an optional priority and a port-state override flag. A management path loads two 32-bit words and then writes one entry with a single strobe, or removes one.

Dynamic entries expire under a periodic aging tick whose period is a parameter. The first tick after a refresh clears the entry's age bit, and the next tick removes the entry if no refresh came in between. In a static entry the age bit means something else: a static entry with that bit set tells downstream logic to forward a matching frame whatever the port state is, except on a disabled port. Static entries are never aged and never changed by learning. A priority stored in an entry is reported only when a global configuration input also allows it.

Top module: `mac_age_table`

## Requirements
- R1: After reset the table is empty, so every lookup misses with all decision outputs at zero, and `table_full` is 0.
- R2: On a `make_entry` pulse whose upper word has bit 26 (valid) set, the entry built from the two loaded words is written. The lower word holds MAC[31:0]. In the upper word, bits 15:0 hold MAC[47:32], bits 17:16 the port, bit 25 age/override, bit 24 static, bit 23 filter, bit 22 priority enable and bits 21:19 the priority. Bits 31:27 are ignored. An entry with the same MAC is overwritten in place; otherwise the lowest free slot is used.
- R3: A `make_entry` pulse whose upper word has bit 26 clear removes any entry with that MAC.
- R4: A learn (`sa_valid`) that misses allocates the lowest free slot as a dynamic entry with the given port, the age bit set, and filter and priority cleared. A learn that hits a dynamic entry replaces its port and sets its age bit.
- R5: A learn never modifies a static entry.
- R6: A learn or a valid `make_entry` that needs a new slot when none is free is dropped and sets `table_full`, which stays at 1 until reset.
- R7: On an aging tick (`age_pulse` high for one cycle, once every AGE_TICK_CYCLES cycles), a dynamic entry with its age bit set has that bit cleared, and a dynamic entry with the bit already clear is removed. Static entries are not affected.
- R8: A lookup reports `da_hit` for a valid matching entry, with its port on `da_port` and its filter bit on `da_filter`. On a miss all of these are 0.
- R9: `da_override` is 1 only for a hit on an entry that has both static and age/override set.
- R10: `da_prio_valid` is 1 and `da_prio` carries the entry's priority only when the hit entry has priority enable set and `cfg_da_prio_en` is 1; otherwise both are 0.
- R11: When a command and a learn name the same MAC in one cycle, the command's entry is stored and the learn is dropped. A lookup in the same cycle sees the table as it was before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sa_valid | input | 1 | Learn request for the source address |
| sa_mac | input | 48 | Source MAC address |
| sa_port | input | 2 | Ingress port of the source frame |
| da_mac | input | 48 | Destination MAC address to look up |
| da_hit | output | 1 | Lookup matched a valid entry |
| da_port | output | 2 | Egress port of the matching entry |
| da_filter | output | 1 | Matching entry asks for the frame to be dropped |
| da_override | output | 1 | Forward regardless of port state (except disabled) |
| da_prio_valid | output | 1 | Priority override applies |
| da_prio | output | 3 | Priority to apply |
| cfg_da_prio_en | input | 1 | Global enable for per-entry priority |
| wr_lo_en | input | 1 | Load the lower command word from wr_data |
| wr_hi_en | input | 1 | Load the upper command word from wr_data |
| wr_data | input | 32 | Command word data |
| make_entry | input | 1 | One-cycle strobe that applies the loaded command |
| table_full | output | 1 | Sticky flag: an entry was dropped for lack of space |
| age_pulse | output | 1 | One-cycle aging tick |

## Verification
The bench builds the block with its default of eight entries, so learning a handful of addresses is enough to fill the table and exercise the dropped-learn path and the sticky flag. The aging period is cut to 400 cycles. Two-tick removal, refresh between ticks and the exemption of static entries can then be shown within a few thousand cycles, while a vector pass of under a hundred cycles still finishes before the first tick.

// File: rtl/mat_pkg.sv
// Package for the MAC address table: field widths, the stored entry
// layout and the bit positions of the upper command word.
// Assumes: the command word format is fixed, so port and priority widths
// follow it.
package mat_pkg;
    parameter int MAC_W  = 48;
    parameter int PORT_W = 2;
    parameter int PRIO_W = 3;

    // Upper command word bit positions (the management path decodes them)
    localparam int HI_VALID    = 26;
    localparam int HI_AGE      = 25;
    localparam int HI_STATIC   = 24;
    localparam int HI_FILTER   = 23;
    localparam int HI_PEN      = 22;
    localparam int HI_PRIO_LSB = 19;
    localparam int HI_PORT_LSB = 16;
    localparam int HI_MAC_W    = MAC_W - 32;

    typedef struct packed {
        logic              valid;
        logic              age;
        logic              stat;
        logic              filt;
        logic              pen;
        logic [PRIO_W-1:0] prio;
        logic [PORT_W-1:0] port;
        logic [MAC_W-1:0]  mac;
    } entry_t;
endpackage

// File: rtl/mat_age_timer.sv
// Aging tick generator. It raises tick for one cycle at the end of every
// PERIOD cycles, counted from reset.
// Assumes: PERIOD >= 2.
module mat_age_timer #(
    parameter int PERIOD = 150_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt_q;

    // Count the cycles and pulse at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == CNT_W'(PERIOD - 1)) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/mat_cmd_regs.sv
// Management holding registers. The lower and upper words are loaded
// separately and then presented, decoded, as one candidate entry.
// Assumes: the caller strobes make_entry only after both words are loaded.
module mat_cmd_regs
    import mat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo_en,
    input  logic        wr_hi_en,
    input  logic [31:0] wr_data,
    output entry_t      cmd_entry
);
    logic [31:0]         lo_q;
    logic [HI_MAC_W-1:0] mac_hi_q;
    logic [PORT_W-1:0]   port_q;
    logic [PRIO_W-1:0]   prio_q;
    logic                valid_q, age_q, stat_q, filt_q, pen_q;

    // Capture the lower word: MAC bits 31:0
    always_ff @(posedge clk) begin
        if (!rst_n)        lo_q <= '0;
        else if (wr_lo_en) lo_q <= wr_data;
    end

    // Capture the used fields of the upper word; reserved bits are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_hi_q <= '0;
            port_q   <= '0;
            prio_q   <= '0;
            valid_q  <= 1'b0;
            age_q    <= 1'b0;
            stat_q   <= 1'b0;
            filt_q   <= 1'b0;
            pen_q    <= 1'b0;
        end else if (wr_hi_en) begin
            mac_hi_q <= wr_data[HI_MAC_W-1:0];
            port_q   <= wr_data[HI_PORT_LSB +: PORT_W];
            prio_q   <= wr_data[HI_PRIO_LSB +: PRIO_W];
            valid_q  <= wr_data[HI_VALID];
            age_q    <= wr_data[HI_AGE];
            stat_q   <= wr_data[HI_STATIC];
            filt_q   <= wr_data[HI_FILTER];
            pen_q    <= wr_data[HI_PEN];
        end
    end

    // Assemble the candidate entry
    always_comb begin
        cmd_entry.valid = valid_q;
        cmd_entry.age   = age_q;
        cmd_entry.stat  = stat_q;
        cmd_entry.filt  = filt_q;
        cmd_entry.pen   = pen_q;
        cmd_entry.prio  = prio_q;
        cmd_entry.port  = port_q;
        cmd_entry.mac   = {mac_hi_q, lo_q};
    end
endmodule

// File: rtl/mat_cam_search.sv
// Associative search of all entries for one key. It returns a hit and the
// lowest matching index. clk and rst_n only clock the uniqueness check.
// Assumes: NUM >= 2; the table keeps at most one valid entry per MAC.
module mat_cam_search
    import mat_pkg::*;
#(
    parameter int NUM   = 8,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  entry_t [NUM-1:0]     tbl,
    input  logic [MAC_W-1:0]     key,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);
    logic [NUM-1:0] hit_vec;

    // One comparator per entry
    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign hit_vec[g] = tbl[g].valid && (tbl[g].mac == key);
    end

    // Encode the lowest matching index
    always_comb begin
        idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

    p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/mac_age_table.sv
// MAC address table with learning, management writes, aging and a
// destination lookup. The update order within a cycle is: aging, then
// learning, then the command, so the command wins. Lookups are
// combinational on the registered table.
// Assumes: NUM_ENTRIES >= 2; AGE_TICK_CYCLES >= 2; the port-state check
// that uses da_override is done downstream.
module mac_age_table
    import mat_pkg::*;
#(
    parameter int NUM_ENTRIES     = 8,
    parameter int AGE_TICK_CYCLES = 150_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa_valid,
    input  logic [MAC_W-1:0]  sa_mac,
    input  logic [PORT_W-1:0] sa_port,
    input  logic [MAC_W-1:0]  da_mac,
    output logic              da_hit,
    output logic [PORT_W-1:0] da_port,
    output logic              da_filter,
    output logic              da_override,
    output logic              da_prio_valid,
    output logic [PRIO_W-1:0] da_prio,
    input  logic              cfg_da_prio_en,
    input  logic              wr_lo_en,
    input  logic              wr_hi_en,
    input  logic [31:0]       wr_data,
    input  logic              make_entry,
    output logic              table_full,
    output logic              age_pulse
);
    localparam int N     = NUM_ENTRIES;
    localparam int IDX_W = $clog2(N);

    entry_t [N-1:0]   tbl_q, tbl_d;
    entry_t           cmd_entry;
    entry_t           da_ent;
    logic             sa_hit, da_hit_w, cmd_hit;
    logic [IDX_W-1:0] sa_idx, da_idx, cmd_idx;
    logic [N-1:0]     free_vec, learn_free_vec;
    logic             cmd_free_found, learn_free_found;
    logic [IDX_W-1:0] cmd_free_idx, learn_free_idx;
    logic             cmd_alloc, learn_block, full_set, full_q;
    logic [N-1:0]     cmd_we_vec, learn_we_vec;

    mat_age_timer #(.PERIOD(AGE_TICK_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(age_pulse)
    );

    mat_cmd_regs u_cmd_regs (
        .clk(clk), .rst_n(rst_n), .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en),
        .wr_data(wr_data), .cmd_entry(cmd_entry)
    );

    mat_cam_search #(.NUM(N)) u_sa_search (
        .clk(clk), .rst_n(rst_n), .tbl(tbl_q), .key(sa_mac),
        .hit(sa_hit), .idx(sa_idx)
    );

    mat_cam_search #(.NUM(N)) u_da_search (
        .clk(clk), .rst_n(rst_n), .tbl(tbl_q), .key(da_mac),
        .hit(da_hit_w), .idx(da_idx)
    );

    mat_cam_search #(.NUM(N)) u_cmd_search (
        .clk(clk), .rst_n(rst_n), .tbl(tbl_q), .key(cmd_entry.mac),
        .hit(cmd_hit), .idx(cmd_idx)
    );

    // Free-slot map of the current table
    for (genvar g = 0; g < N; g++) begin : g_free
        assign free_vec[g] = !tbl_q[g].valid;
    end

    // Lowest free slot for a command allocation
    always_comb begin
        cmd_free_found = 1'b0;
        cmd_free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                cmd_free_found = 1'b1;
                cmd_free_idx   = IDX_W'(i);
            end
        end
    end

    assign cmd_alloc   = make_entry && cmd_entry.valid && !cmd_hit && cmd_free_found;
    assign learn_block = make_entry && (sa_mac == cmd_entry.mac);
    assign learn_free_vec = free_vec & ~(cmd_alloc ? (N'(1) << cmd_free_idx) : N'(0));

    // Lowest free slot for a learn, not counting the slot a command takes
    always_comb begin
        learn_free_found = 1'b0;
        learn_free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (learn_free_vec[i]) begin
                learn_free_found = 1'b1;
                learn_free_idx   = IDX_W'(i);
            end
        end
    end

    // Next table state: aging, then learning, then the command
    always_comb begin
        tbl_d        = tbl_q;
        cmd_we_vec   = '0;
        learn_we_vec = '0;
        full_set     = 1'b0;
        if (age_pulse) begin
            for (int i = 0; i < N; i++) begin
                if (tbl_q[i].valid && !tbl_q[i].stat) begin
                    if (tbl_q[i].age) tbl_d[i].age   = 1'b0;
                    else              tbl_d[i].valid = 1'b0;
                end
            end
        end
        if (sa_valid && !learn_block) begin
            if (sa_hit) begin
                if (!tbl_q[sa_idx].stat) begin
                    tbl_d[sa_idx]      = tbl_q[sa_idx];
                    tbl_d[sa_idx].port = sa_port;
                    tbl_d[sa_idx].age  = 1'b1;
                    learn_we_vec[sa_idx] = 1'b1;
                end
            end else if (learn_free_found) begin
                tbl_d[learn_free_idx]       = '0;
                tbl_d[learn_free_idx].valid = 1'b1;
                tbl_d[learn_free_idx].age   = 1'b1;
                tbl_d[learn_free_idx].port  = sa_port;
                tbl_d[learn_free_idx].mac   = sa_mac;
                learn_we_vec[learn_free_idx] = 1'b1;
            end else begin
                full_set = 1'b1;
            end
        end
        if (make_entry) begin
            if (cmd_hit) begin
                tbl_d[cmd_idx]      = cmd_entry.valid ? cmd_entry : '0;
                cmd_we_vec[cmd_idx] = 1'b1;
            end else if (cmd_entry.valid) begin
                if (cmd_free_found) begin
                    tbl_d[cmd_free_idx]      = cmd_entry;
                    cmd_we_vec[cmd_free_idx] = 1'b1;
                end else begin
                    full_set = 1'b1;
                end
            end
        end
    end

    // Table and sticky full-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q  <= '0;
            full_q <= 1'b0;
        end else begin
            tbl_q  <= tbl_d;
            full_q <= full_q | full_set;
        end
    end

    assign table_full = full_q;

    // Destination decision from the matching entry
    always_comb begin
        da_ent        = tbl_q[da_idx];
        da_hit        = da_hit_w;
        da_port       = da_hit_w ? da_ent.port : '0;
        da_filter     = da_hit_w && da_ent.filt;
        da_override   = da_hit_w && da_ent.stat && da_ent.age;
        da_prio_valid = da_hit_w && da_ent.pen && cfg_da_prio_en;
        da_prio       = da_prio_valid ? da_ent.prio : '0;
    end

    p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        table_full |=> table_full);

    p_prio_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        da_prio_valid |-> (cfg_da_prio_en && da_hit));

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_static_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (tbl_q[g].valid && tbl_q[g].stat && !cmd_we_vec[g])
            |=> $stable(tbl_q[g]));

        p_age_remove_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (age_pulse && tbl_q[g].valid && !tbl_q[g].stat && !tbl_q[g].age
             && !cmd_we_vec[g] && !learn_we_vec[g])
            |=> !tbl_q[g].valid);
    end
endmodule

// File: tb/mac_age_table_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, priority gating, same-cycle conflict, aging and a full table.
module mac_age_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;
    localparam int AGE_CYC    = 400;

    localparam logic [1:0] OP_MAKE  = 2'd0;
    localparam logic [1:0] OP_LEARN = 2'd1;
    localparam logic [1:0] OP_LOOK  = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [47:0] mac;
        logic [31:0] flags;
        logic        e_hit;
        logic [1:0]  e_port;
        logic        e_filt;
        logic        e_ovr;
        logic        e_pv;
        logic [2:0]  e_prio;
    } vec_t;

    localparam logic [47:0] MA = 48'h0011_2233_4455;
    localparam logic [47:0] MB = 48'h0A0B_0C0D_0E0F;
    localparam logic [47:0] MC = 48'h0200_0000_0001;
    localparam logic [47:0] MD = 48'h0000_0000_00FF;
    localparam logic [47:0] ME = 48'hFFFF_FFFF_FFFF;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{OP_MAKE,  MA, 32'h0701_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  MA, 32'h0,         1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 3'd0},
        '{OP_MAKE,  MB, 32'hFDEA_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  MB, 32'h0,         1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 3'd5},
        '{OP_LEARN, MC, 32'h0003_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  MC, 32'h0,         1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LEARN, MC, 32'h0000_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  MC, 32'h0,         1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LEARN, MA, 32'h0003_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  MA, 32'h0,         1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 3'd0},
        '{OP_MAKE,  MA, 32'h0000_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  MA, 32'h0,         1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_MAKE,  MD, 32'h065A_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  MD, 32'h0,         1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 3'd3},
        '{OP_MAKE,  MB, 32'h0600_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  MB, 32'h0,         1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{OP_LOOK,  ME, 32'h0,         1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sa_valid = 1'b0;
    logic [47:0] sa_mac = '0;
    logic [1:0]  sa_port = '0;
    logic [47:0] da_mac = '0;
    logic        cfg_da_prio_en = 1'b1;
    logic        wr_lo_en = 1'b0, wr_hi_en = 1'b0, make_entry = 1'b0;
    logic [31:0] wr_data = '0;
    logic        da_hit, da_filter, da_override, da_prio_valid, table_full, age_pulse;
    logic [1:0]  da_port;
    logic [2:0]  da_prio;

    int checks = 0;
    int errors = 0;

    mac_age_table #(.NUM_ENTRIES(ENTRIES), .AGE_TICK_CYCLES(AGE_CYC)) u_mac_age_table (
        .clk(clk), .rst_n(rst_n), .sa_valid(sa_valid), .sa_mac(sa_mac),
        .sa_port(sa_port), .da_mac(da_mac), .da_hit(da_hit), .da_port(da_port),
        .da_filter(da_filter), .da_override(da_override),
        .da_prio_valid(da_prio_valid), .da_prio(da_prio),
        .cfg_da_prio_en(cfg_da_prio_en), .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en),
        .wr_data(wr_data), .make_entry(make_entry), .table_full(table_full),
        .age_pulse(age_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Look up mac and compare the whole decision {hit,port,filt,ovr,pv,prio}
    task automatic look(input string tag, input logic [47:0] mac, input logic hit,
                        input logic [1:0] port, input logic filt, input logic ovr,
                        input logic pv, input logic [2:0] prio);
        da_mac = mac;
        #1;
        check1(tag, {23'd0, da_hit, da_port, da_filter, da_override, da_prio_valid, da_prio},
               {23'd0, hit, port, filt, ovr, pv, prio});
    endtask

    task automatic load_words(input logic [47:0] mac, input logic [31:0] flags);
        @(negedge clk); wr_lo_en = 1'b1; wr_data = mac[31:0];
        @(negedge clk); wr_lo_en = 1'b0; wr_hi_en = 1'b1; wr_data = flags | {16'd0, mac[47:32]};
        @(negedge clk); wr_hi_en = 1'b0;
    endtask

    task automatic make(input logic [47:0] mac, input logic [31:0] flags);
        load_words(mac, flags);
        make_entry = 1'b1;
        @(negedge clk); make_entry = 1'b0;
    endtask

    task automatic learn(input logic [47:0] mac, input logic [1:0] port);
        @(negedge clk); sa_valid = 1'b1; sa_mac = mac; sa_port = port;
        @(negedge clk); sa_valid = 1'b0;
    endtask

    // Return at the negedge just after the posedge that applies a tick
    task automatic wait_tick();
        while (!age_pulse) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100_000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        look("R1 reset lookup", MA, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        check1("R1 reset full flag", {31'd0, table_full}, 32'd0);

        // Vector pass: R2 R3 R4 R5 R8 R9 R10 (reserved bits set in vector 2)
        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                OP_MAKE:  make(VECS[v].mac, VECS[v].flags);
                OP_LEARN: learn(VECS[v].mac, VECS[v].flags[17:16]);
                default:  look($sformatf("vector %0d R2 R3 R4 R5 R8 R9 R10", v),
                               VECS[v].mac, VECS[v].e_hit, VECS[v].e_port,
                               VECS[v].e_filt, VECS[v].e_ovr, VECS[v].e_pv,
                               VECS[v].e_prio);
            endcase
        end

        // R1: reset in mid-run empties the table
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        look("R1 reset clears B", MB, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        look("R1 reset clears D", MD, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);

        // R10: global enable gates priority
        make(48'h0000_0000_0F0F, 32'h057E_0000);
        cfg_da_prio_en = 1'b0;
        look("R10 gate off", 48'h0000_0000_0F0F, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0);
        cfg_da_prio_en = 1'b1;
        look("R10 gate on", 48'h0000_0000_0F0F, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 3'd7);

        // R11: command and learn on the same MAC in one cycle
        load_words(48'h0000_0000_1234, 32'h0503_0000);
        make_entry = 1'b1; sa_valid = 1'b1; sa_mac = 48'h0000_0000_1234; sa_port = 2'd1;
        look("R11 lookup sees old state", 48'h0000_0000_1234, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        @(negedge clk); make_entry = 1'b0; sa_valid = 1'b0;
        look("R11 command wins", 48'h0000_0000_1234, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0);

        // R7: dynamic entry survives one tick, is removed at the second
        learn(48'h0000_0000_AAAA, 2'd1);
        wait_tick();
        look("R7 after first tick", 48'h0000_0000_AAAA, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0);
        wait_tick();
        look("R7 after second tick", 48'h0000_0000_AAAA, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        look("R7 static not aged", 48'h0000_0000_1234, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0);

        // R4 R7: a refresh between ticks restarts aging
        learn(48'h0000_0000_BBBB, 2'd2);
        wait_tick();
        learn(48'h0000_0000_BBBB, 2'd2);
        wait_tick();
        look("R4 R7 refreshed survives", 48'h0000_0000_BBBB, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0);
        wait_tick();
        look("R7 refreshed removed", 48'h0000_0000_BBBB, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);

        // R6: two static entries remain; six learns fill the table
        for (int k = 0; k < ENTRIES - 2; k++) learn(48'h0000_0100_0000 + 48'(k), 2'(k));
        check1("R6 not full yet", {31'd0, table_full}, 32'd0);
        look("R6 last fill entry", 48'h0000_0100_0005, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0);
        learn(48'h0000_0200_0000, 2'd3);
        check1("R6 full flag set", {31'd0, table_full}, 32'd1);
        look("R6 dropped learn", 48'h0000_0200_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        repeat (3) @(negedge clk);
        check1("R6 full flag sticky", {31'd0, table_full}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule